// File: doc/BRIEF.md
# Interlocked Parallel Port Host Engine

This block is the host end of an enhanced parallel port. A simple request/ready bus presents single reads and writes at a 3-bit offset from the port base. Accesses at offset 4 become data transfers and accesses at offset 3 become address transfers. Each transfer runs as an interlocked four-edge strobe/wait exchange on the cable, in either direction. The three low offsets act as the classic parallel port registers and never touch the strobes.

One bus access covers the whole cable transaction. The bus side stays not-ready until the peripheral has released its wait line at the end of the last byte. A 32-bit data access becomes four byte transfers, lowest byte first. A pre-standard mode input makes the strobe assert without first looking at the wait line. The cable data bus is split into input, output and output-enable for an external pad.

Top module: `ppx_host`

## Requirements
- R1: A write at offset 4 runs one transfer on `n_dstrb` with `n_wr` low and puts `bus_wdata[7:0]` on `pd_out`. A read at offset 4 runs one transfer on `n_dstrb` with `n_wr` high, and `bus_rdata` returns the byte zero-extended.
- R2: Any access at offset 3 runs exactly one transfer on `n_astrb`, even when `bus_wide` is set.
- R3: Offset 0 is a read/write data latch and offset 2 is a read/write control latch. Offset 1 reads `spp_status`, and writes to it have no effect. Offsets 5 to 7 complete with read data 0. None of these accesses moves a strobe. When no transfer is running, `pd_out` shows the data latch, and `pd_oe` is the inverse of control bit 5 (1 means the host does not drive the data bus).
- R4: With `legacy_mode` low, a strobe never falls while the synchronized `n_wait_in` is high, so the peripheral can hold off the start of a transfer.
- R5: A strobe rises only after `n_wait_in` has been seen high. The next byte or the bus completion follows only after `n_wait_in` has been seen low again.
- R6: With `legacy_mode` high, the strobe falls at the start of a transfer even while `n_wait_in` is high.
- R7: A data access with `bus_wide` set runs four transfers that carry bytes 0, 1, 2 and 3 in that order. On a read, byte k lands in `bus_rdata[8k+7:8k]`.
- R8: `bus_ready` stays low while any strobe is asserted or the peripheral is busy. It then goes high and holds until `bus_req` drops.
- R9: During every transfer, `n_wr` is settled before the strobe falls and holds steady while the strobe is low. `pd_oe` is high during write transfers and low during read transfers.
- R10: Read data is captured when the wait line is seen rising, while the strobe is still low. Data that changes during the recovery phase is not used.
- R11: After reset both strobes and `n_wr` are high, `bus_ready` is low, `bus_rdata` is 0, `pd_out` is 0 and `pd_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| legacy_mode | input | 1 | 1: strobe asserts without checking the wait line |
| bus_req | input | 1 | Access request, held until `bus_ready` |
| bus_we | input | 1 | 1 for write access |
| bus_ofs | input | 3 | Register offset from the port base |
| bus_wide | input | 1 | 32-bit access (used at offset 4 only) |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access complete |
| bus_rdata | output | 32 | Read data |
| n_dstrb | output | 1 | Data strobe, active low |
| n_astrb | output | 1 | Address strobe, active low |
| n_wr | output | 1 | Low for write transfers |
| n_wait_in | input | 1 | Peripheral wait line, high means busy |
| pd_in | input | 8 | Cable data from the pad |
| pd_out | output | 8 | Cable data to the pad |
| pd_oe | output | 1 | Pad output enable |
| spp_status | input | 8 | Status lines returned at offset 1 |

## Verification
A wrong handshake state shows on the cable within one or two cycles. It appears as a strobe falling against a busy wait line, a strobe rising before the wait line rose, or a byte that reaches the peripheral twice or out of order. A byte-index or capture error appears in `bus_rdata` or the captured byte sequence when the same access completes. A stuck or early completion shows as `bus_ready` rising while the cable is still mid-exchange, or never rising, which the access loop detects within its guard time.

// File: rtl/ppx_pkg.sv
package ppx_pkg;

    localparam int BYTE_W       = 8;
    localparam int OFS_W        = 3;
    localparam int CTRL_DIR_BIT = 5;

    localparam logic [OFS_W-1:0] OFS_LATCH  = 3'd0;
    localparam logic [OFS_W-1:0] OFS_STATUS = 3'd1;
    localparam logic [OFS_W-1:0] OFS_CTRL   = 3'd2;
    localparam logic [OFS_W-1:0] OFS_ADDR   = 3'd3;
    localparam logic [OFS_W-1:0] OFS_DATA   = 3'd4;

    typedef enum logic [2:0] {
        HS_IDLE,
        HS_SETUP,
        HS_ARM,
        HS_STRB,
        HS_RECOV,
        HS_DONE
    } hs_state_e;

    typedef struct packed {
        logic we;
        logic addr_cyc;
        logic wide;
    } xfer_t;

    function automatic logic is_cable_ofs(input logic [OFS_W-1:0] ofs);
        return (ofs == OFS_ADDR) || (ofs == OFS_DATA);
    endfunction

endpackage

// File: rtl/ppx_sync.sv
module ppx_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ppx_spp_regs.sv
module ppx_spp_regs
    import ppx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] status_in,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [BYTE_W-1:0] latch_q,
    output logic [BYTE_W-1:0] ctrl_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            ctrl_q  <= '0;
        end else if (wr_en) begin
            if (ofs == OFS_LATCH) latch_q <= wdata;
            if (ofs == OFS_CTRL)  ctrl_q  <= wdata;
        end
    end

    always_comb begin
        case (ofs)
            OFS_LATCH:  rd_byte = latch_q;
            OFS_STATUS: rd_byte = status_in;
            OFS_CTRL:   rd_byte = ctrl_q;
            default:    rd_byte = '0;
        endcase
    end
endmodule

// File: rtl/ppx_hs_engine.sv
module ppx_hs_engine
    import ppx_pkg::*;
#(
    parameter int NBYTES = 4,
    localparam int DATA_W = NBYTES * BYTE_W,
    localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              legacy_mode,
    input  logic              req,
    input  logic              we,
    input  logic [OFS_W-1:0]  ofs,
    input  logic              wide,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wait_busy,
    input  logic [BYTE_W-1:0] pd_in,
    input  logic [BYTE_W-1:0] simple_rdata,
    output logic              simple_wr,
    output logic              ready,
    output logic [DATA_W-1:0] rdata,
    output logic              dstrb_n,
    output logic              astrb_n,
    output logic              wr_n,
    output logic              active,
    output logic              drive,
    output logic [BYTE_W-1:0] tx_byte
);
    hs_state_e          state;
    xfer_t              x;
    logic [IDX_W-1:0]   idx;
    logic [DATA_W-1:0]  wdata_q;
    logic [DATA_W-1:0]  rdata_q;
    logic               last;
    logic               strb_on;
    logic               strb_any_n;

    assign last = !x.wide || (idx == IDX_W'(NBYTES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= HS_IDLE;
            x       <= '0;
            idx     <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            case (state)
                HS_IDLE: if (req) begin
                    x.we       <= we;
                    x.addr_cyc <= (ofs == OFS_ADDR);
                    x.wide     <= wide && (ofs == OFS_DATA);
                    idx        <= '0;
                    wdata_q    <= wdata;
                    if (is_cable_ofs(ofs)) begin
                        rdata_q <= '0;
                        state   <= HS_SETUP;
                    end else begin
                        rdata_q <= {{(DATA_W-BYTE_W){1'b0}}, simple_rdata};
                        state   <= HS_DONE;
                    end
                end
                HS_SETUP: state <= HS_ARM;
                HS_ARM: if (legacy_mode || !wait_busy) state <= HS_STRB;
                HS_STRB: if (wait_busy) begin
                    if (!x.we) rdata_q[idx*BYTE_W +: BYTE_W] <= pd_in;
                    state <= HS_RECOV;
                end
                HS_RECOV: if (!wait_busy) begin
                    if (last) state <= HS_DONE;
                    else begin
                        idx   <= idx + 1'b1;
                        state <= HS_SETUP;
                    end
                end
                HS_DONE: if (!req) state <= HS_IDLE;
                default: state <= HS_IDLE;
            endcase
        end
    end

    assign active     = (state == HS_SETUP) || (state == HS_ARM) ||
                        (state == HS_STRB)  || (state == HS_RECOV);
    assign strb_on    = (state == HS_STRB);
    assign dstrb_n    = !(strb_on && !x.addr_cyc);
    assign astrb_n    = !(strb_on &&  x.addr_cyc);
    assign wr_n       = !(active && x.we);
    assign drive      = active && x.we;
    assign tx_byte    = wdata_q[idx*BYTE_W +: BYTE_W];
    assign ready      = (state == HS_DONE);
    assign rdata      = rdata_q;
    assign simple_wr  = (state == HS_IDLE) && req && we && !is_cable_ofs(ofs);
    assign strb_any_n = dstrb_n && astrb_n;

    // R4: in standard mode the strobe falls only while the peripheral is ready
    p_holdoff_r4: assert property (@(posedge clk) disable iff (rst)
        ($fell(strb_any_n) && !legacy_mode) |-> !$past(wait_busy));

    // R5: the strobe is released only after the wait line was seen high
    p_release_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(strb_any_n) |-> $past(wait_busy));

    // R9: write direction is steady across the whole strobe
    p_wr_steady_r9: assert property (@(posedge clk) disable iff (rst)
        !strb_any_n |-> (wr_n == $past(wr_n)));

    // R8: completion is never flagged while the cable is mid-exchange
    p_ready_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        ready |-> (strb_any_n && !wait_busy) || !$past(active));
endmodule

// File: rtl/ppx_host.sv
module ppx_host
    import ppx_pkg::*;
#(
    parameter int NBYTES      = 4,
    parameter int SYNC_STAGES = 2,
    localparam int DATA_W = NBYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              legacy_mode,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [OFS_W-1:0]  bus_ofs,
    input  logic              bus_wide,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ready,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              n_dstrb,
    output logic              n_astrb,
    output logic              n_wr,
    input  logic              n_wait_in,
    input  logic [BYTE_W-1:0] pd_in,
    output logic [BYTE_W-1:0] pd_out,
    output logic              pd_oe,
    input  logic [BYTE_W-1:0] spp_status
);
    logic              wait_busy;
    logic              simple_wr;
    logic [BYTE_W-1:0] simple_rd;
    logic [BYTE_W-1:0] latch_q;
    logic [BYTE_W-1:0] ctrl_q;
    logic              eng_active;
    logic              eng_drive;
    logic [BYTE_W-1:0] tx_byte;

    ppx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_wait_sync (
        .clk (clk),
        .rst (rst),
        .d   (n_wait_in),
        .q   (wait_busy)
    );

    ppx_spp_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (simple_wr),
        .ofs       (bus_ofs),
        .wdata     (bus_wdata[BYTE_W-1:0]),
        .status_in (spp_status),
        .rd_byte   (simple_rd),
        .latch_q   (latch_q),
        .ctrl_q    (ctrl_q)
    );

    ppx_hs_engine #(.NBYTES(NBYTES)) u_engine (
        .clk          (clk),
        .rst          (rst),
        .legacy_mode  (legacy_mode),
        .req          (bus_req),
        .we           (bus_we),
        .ofs          (bus_ofs),
        .wide         (bus_wide),
        .wdata        (bus_wdata),
        .wait_busy    (wait_busy),
        .pd_in        (pd_in),
        .simple_rdata (simple_rd),
        .simple_wr    (simple_wr),
        .ready        (bus_ready),
        .rdata        (bus_rdata),
        .dstrb_n      (n_dstrb),
        .astrb_n      (n_astrb),
        .wr_n         (n_wr),
        .active       (eng_active),
        .drive        (eng_drive),
        .tx_byte      (tx_byte)
    );

    assign pd_out = eng_active ? tx_byte   : latch_q;
    assign pd_oe  = eng_active ? eng_drive : !ctrl_q[CTRL_DIR_BIT];

    // R9: the host never drives the cable during a read strobe
    p_no_drive_read_r9: assert property (@(posedge clk) disable iff (rst)
        (!(n_dstrb && n_astrb) && n_wr) |-> !pd_oe);

    // R9: the host drives the cable during a write strobe
    p_drive_write_r9: assert property (@(posedge clk) disable iff (rst)
        (!(n_dstrb && n_astrb) && !n_wr) |-> pd_oe);
endmodule

// File: tb/ppx_host_tb.sv
`timescale 1ns/1ps
module ppx_host_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        legacy_mode = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_ofs = '0;
    logic        bus_wide = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready;
    logic [31:0] bus_rdata;
    logic        n_dstrb, n_astrb, n_wr;
    logic        per_wait = 1'b0;
    logic        hold_busy = 1'b0;
    logic        n_wait_in;
    logic [7:0]  pd_in = '0;
    logic [7:0]  pd_out;
    logic        pd_oe;
    logic [7:0]  spp_status = 8'h5A;

    int tests = 0;
    int fails = 0;
    int falls = 0;
    int per_n = 0;
    int dly = 1;
    logic [7:0] resp [4];
    logic [7:0] cap [4];
    logic       cap_addr, cap_wr_n;
    logic       seq_err = 0, ready_err = 0, oe_err = 0, wr_err = 0, held_bad = 0;

    assign n_wait_in = per_wait | hold_busy;

    always #2.5 clk = ~clk;

    ppx_host u_dut (
        .clk(clk), .rst(rst), .legacy_mode(legacy_mode),
        .bus_req(bus_req), .bus_we(bus_we), .bus_ofs(bus_ofs), .bus_wide(bus_wide),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .n_dstrb(n_dstrb), .n_astrb(n_astrb), .n_wr(n_wr), .n_wait_in(n_wait_in),
        .pd_in(pd_in), .pd_out(pd_out), .pd_oe(pd_oe), .spp_status(spp_status)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Cable monitor: ordering, completion and drive rules
    initial begin
        logic prev_low = 1'b0;
        logic prev_wait = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                logic low;
                low = !n_dstrb || !n_astrb;
                if (low && !prev_low) begin
                    falls++;
                    if (!legacy_mode && prev_wait) seq_err = 1;      // R4
                end
                if (!low && prev_low && !prev_wait && !n_wait_in) seq_err = 1; // R5
                if (bus_ready && (low || n_wait_in)) ready_err = 1; // R8
                prev_low  = low;
                prev_wait = n_wait_in;
            end
        end
    end

    // Peripheral model
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && (!n_dstrb || !n_astrb)) begin
                int k;
                logic wr0;
                k = per_n % 4;
                cap_addr = !n_astrb;
                wr0 = n_wr;
                cap_wr_n = n_wr;
                pd_in = ~resp[k];
                repeat (dly) @(negedge clk);
                cap[k] = pd_out;
                if (n_wr != wr0) wr_err = 1;
                if (!n_dstrb || !n_astrb) begin
                    if (n_wr ? pd_oe : !pd_oe) oe_err = 1;
                end
                pd_in = resp[k];
                per_wait = 1'b1;
                while (!n_dstrb || !n_astrb) begin
                    @(negedge clk);
                    if ((!n_dstrb || !n_astrb) && n_wr != wr0) wr_err = 1;
                end
                repeat (dly) @(negedge clk);
                per_wait = 1'b0;
                pd_in = ~resp[k];
                per_n++;
            end
        end
    end

    task automatic do_acc(input logic we, input logic [2:0] ofs, input logic wide,
                          input logic [31:0] wd, input int extra, output logic [31:0] rd);
        int guard;
        @(negedge clk);
        per_n = 0;
        bus_req = 1'b1; bus_we = we; bus_ofs = ofs; bus_wide = wide; bus_wdata = wd;
        @(negedge clk);
        guard = 0;
        while (!bus_ready && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        rd = bus_rdata;
        for (int i = 0; i < extra; i++) begin
            @(negedge clk);
            if (!bus_ready) held_bad = 1;
        end
        bus_req = 1'b0;
        @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int f0;
        for (int i = 0; i < 4; i++) begin resp[i] = 8'h00; cap[i] = 8'h00; end
        repeat (4) @(negedge clk);
        // R11 reset state, sampled during reset
        check(n_dstrb && n_astrb && n_wr, "R11 strobes idle", {29'b0, n_dstrb, n_astrb, n_wr}, 32'h7);
        check(!bus_ready && bus_rdata == 0, "R11 bus idle", bus_rdata, 0);
        check(pd_oe && pd_out == 0, "R11 pad", {23'b0, pd_oe, pd_out}, 32'h100);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R3 classic registers
        f0 = falls;
        do_acc(1, 3'd0, 0, 32'hA5, 0, rd);
        do_acc(0, 3'd0, 0, 0, 0, rd);
        check(rd == 32'hA5, "R3 latch readback", rd, 32'hA5);
        check(pd_out == 8'hA5 && pd_oe, "R3 latch on pad", {23'b0, pd_oe, pd_out}, 32'h1A5);
        do_acc(1, 3'd2, 0, 32'h20, 0, rd);
        check(!pd_oe, "R3 ctrl bit5 releases pad", pd_oe, 0);
        do_acc(0, 3'd2, 0, 0, 0, rd);
        check(rd == 32'h20, "R3 ctrl readback", rd, 32'h20);
        do_acc(1, 3'd2, 0, 32'h00, 0, rd);
        do_acc(1, 3'd1, 0, 32'hFF, 0, rd);
        do_acc(0, 3'd1, 0, 0, 0, rd);
        check(rd == 32'h5A, "R3 status read-only", rd, 32'h5A);
        do_acc(0, 3'd6, 0, 0, 0, rd);
        check(rd == 0, "R3 upper offset reads zero", rd, 0);
        check(falls == f0, "R3 no strobe", falls - f0, 0);

        // R1 / R10 sweep over all byte values, data write and read
        for (int v = 0; v < 256; v++) begin
            dly = 1 + v % 3;
            do_acc(1, 3'd4, 0, {24'hDEADBE, v[7:0]}, 0, rd);
            check(per_n == 1 && cap[0] == v[7:0] && !cap_wr_n && !cap_addr,
                  "R1 data write", {cap_addr, cap_wr_n, cap[0]}, {2'b00, v[7:0]});
            resp[0] = v[7:0] ^ 8'h3C;
            do_acc(0, 3'd4, 0, 0, 0, rd);
            check(per_n == 1 && rd == {24'h0, v[7:0] ^ 8'h3C} && cap_wr_n && !cap_addr,
                  "R1 R10 data read", rd, {24'h0, v[7:0] ^ 8'h3C});
        end

        // R2 address cycles, wide flag ignored
        for (int v = 0; v < 16; v++) begin
            dly = 1 + v % 4;
            do_acc(1, 3'd3, 1, {4{v[3:0], 4'h9}}, 0, rd);
            check(per_n == 1 && cap_addr && cap[0] == {v[3:0], 4'h9}, "R2 address write",
                  {per_n[7:0], cap[0]}, {8'd1, v[3:0], 4'h9});
            resp[0] = {4'h6, v[3:0]};
            do_acc(0, 3'd3, 1, 0, 0, rd);
            check(per_n == 1 && cap_addr && rd == {24'h0, 4'h6, v[3:0]}, "R2 address read",
                  rd, {24'h0, 4'h6, v[3:0]});
        end

        // R7 wide transfers
        for (int v = 0; v < 8; v++) begin
            logic [31:0] w;
            w = 32'h11223344 + v * 32'h01010101;
            dly = 1 + v % 2;
            do_acc(1, 3'd4, 1, w, 0, rd);
            check(per_n == 4 && {cap[3], cap[2], cap[1], cap[0]} == w, "R7 wide write order",
                  {cap[3], cap[2], cap[1], cap[0]}, w);
            for (int i = 0; i < 4; i++) resp[i] = 8'hA0 + 8'(i) + 8'(v * 16);
            do_acc(0, 3'd4, 1, 0, 0, rd);
            check(per_n == 4 && rd == {resp[3], resp[2], resp[1], resp[0]}, "R7 wide read assembly",
                  rd, {resp[3], resp[2], resp[1], resp[0]});
        end

        // R8 ready held while request stays up
        held_bad = 0;
        do_acc(1, 3'd4, 0, 32'h77, 3, rd);
        check(!held_bad, "R8 ready holds", held_bad, 0);

        // R4 hold-off in standard mode
        dly = 2;
        hold_busy = 1'b1;
        repeat (4) @(negedge clk);
        f0 = falls;
        fork
            do_acc(1, 3'd4, 0, 32'h5C, 0, rd);
            begin
                repeat (25) @(negedge clk);
                check(falls == f0, "R4 strobe held off", falls - f0, 0);
                hold_busy = 1'b0;
            end
        join
        check(per_n == 1 && cap[0] == 8'h5C, "R4 transfer after release", cap[0], 8'h5C);

        // R6 legacy mode strobes regardless of wait
        legacy_mode = 1'b1;
        hold_busy = 1'b1;
        repeat (4) @(negedge clk);
        f0 = falls;
        fork
            do_acc(1, 3'd4, 0, 32'h3E, 0, rd);
            begin
                repeat (25) @(negedge clk);
                check(falls > f0, "R6 strobe without wait check", falls - f0, 1);
                hold_busy = 1'b0;
            end
        join
        legacy_mode = 1'b0;
        repeat (4) @(negedge clk);

        check(!seq_err, "R5 four-edge ordering", seq_err, 0);
        check(!ready_err, "R8 ready only after exchange", ready_err, 0);
        check(!oe_err, "R9 pad enable by direction", oe_err, 0);
        check(!wr_err, "R9 n_wr steady", wr_err, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule